// File: doc/BRIEF.md
# Sequential Vertex-by-Matrix Transform Unit

This block multiplies one homogeneous vertex by a 4x4 transform matrix held in local registers. All values are signed fixed point. Software-side logic writes the sixteen matrix elements one at a time through a simple write port while the unit is idle. A `start` pulse then captures the three vertex components (x, y, z), and a fourth component of constant 1.0 is added to them.

Four multiply-accumulate columns run in parallel, one for each output component. A small sequencer steps through the matrix rows, one row per clock. On each step it feeds the matching vertex component to every column. After four accumulation steps a one-cycle `done` pulse marks the result as valid. The four results stay on the outputs until the next accepted start.

Each output is `out[c] = x*M[0][c] + y*M[1][c] + z*M[2][c] + 1.0*M[3][c]`. Each product is scaled back to the input format before it is accumulated.

Top module: `vmat4_xform`

## Requirements
- R1: After reset, `busy` and `done` are low, all four outputs are zero, and every matrix element is zero.
- R2: For column c (0 = out_x, 1 = out_y, 2 = out_z, 3 = out_w), the result is the sum over rows r = 0..3 of v[r]*M[r][c]. Here v = (x, y, z, 1.0), and 1.0 is 1 shifted left by FRAC_W.
- R3: Each product is the full 2*DATA_W-bit signed product shifted right by FRAC_W, which rounds toward minus infinity. Its low DATA_W bits are added into a DATA_W-bit accumulator that wraps on overflow.
- R4: Suppose `start` is sampled high at clock edge k while idle. Then `done` is high for exactly one cycle, from edge k+4 to edge k+5, and is low at every other time.
- R5: `busy` is high from edge k until edge k+5. A `start` sampled while `busy` is high is ignored: no second run occurs and no extra `done` is produced.
- R6: The first accumulation step of every run discards the previous accumulator contents. A run's result never depends on earlier runs.
- R7: While `busy` is low, the outputs hold their last value, whatever the vertex and matrix inputs do, until the edge after a new start is accepted.
- R8: A write (`cfg_we` high while idle) stores `cfg_data` into element M[cfg_row][cfg_col]. A write sampled while `busy` is high is discarded.
- R9: A write and an accepted start in the same cycle both take effect, and that run uses the newly written element.
- R10: The vertex inputs are captured at the accepted start. Changing them while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Matrix element write strobe |
| cfg_row | input | 2 | Row index of the element written |
| cfg_col | input | 2 | Column index of the element written |
| cfg_data | input | DATA_W | Element value, signed fixed point |
| start | input | 1 | Launches a transform when idle |
| vtx_x | input | DATA_W | Vertex x component |
| vtx_y | input | DATA_W | Vertex y component |
| vtx_z | input | DATA_W | Vertex z component |
| busy | output | 1 | A transform is in progress |
| done | output | 1 | One-cycle pulse: outputs are valid |
| out_x | output | DATA_W | Result column 0 |
| out_y | output | DATA_W | Result column 1 |
| out_z | output | DATA_W | Result column 2 |
| out_w | output | DATA_W | Result column 3 |

## Verification
Two events can share a cycle: a matrix write and a start pulse.

- **Idle case.** The bench presents both in the cycle where the start is accepted. It expects the fresh element in that very result.
- **Busy case.** The bench holds a write, a second start and new vertex values through the busy cycles. It then requires three things: the result of the running transform is unchanged, there is only one `done`, and the written element does not appear in later runs.

These directed cases are mixed with seeded random matrices and vertices, including full-range values that wrap. Every result is compared against a reference sum computed in the bench.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

   // Dimension of the homogeneous transform (fixed by the datapath shape).
   localparam int DIM    = 4;
   localparam int IDX_W  = $clog2(DIM);
   localparam int COMPS  = DIM - 1;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_FIN  = 2'd2
   } sq_state_e;

endpackage

// File: rtl/vmx_seq.sv
module vmx_seq
   import vmx_pkg::*;
#(
   parameter int STEPS = DIM,
   localparam int IW   = $clog2(STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          accept,
   output logic          acc_en,
   output logic          init,
   output logic [IW-1:0] row
);

   sq_state_e     st_q, st_d;
   logic [IW-1:0] row_q, row_d;
   logic          last_row;

   assign last_row = (row_q == IW'(STEPS - 1));

   always_comb begin
      st_d  = st_q;
      row_d = row_q;
      unique case (st_q)
         SQ_IDLE: begin
            if (start) begin
               st_d  = SQ_RUN;
               row_d = '0;
            end
         end
         SQ_RUN: begin
            if (last_row) st_d = SQ_FIN;
            else          row_d = row_q + IW'(1);
         end
         SQ_FIN:  st_d = SQ_IDLE;
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         row_q <= '0;
      end else begin
         st_q  <= st_d;
         row_q <= row_d;
      end
   end

   assign busy   = (st_q != SQ_IDLE);
   assign done   = (st_q == SQ_FIN);
   assign accept = (st_q == SQ_IDLE) && start;
   assign acc_en = (st_q == SQ_RUN);
   assign init   = (st_q == SQ_RUN) && (row_q == '0);
   assign row    = row_q;

   // R4: the completion pulse lasts one cycle and ends the busy span
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R5: once launched, busy persists until the completion cycle
   a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R6: an accepted start always opens with an initialising step on row 0
   a_r6_first_step_init: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (acc_en && init && row == '0));

   // R5: a start seen while busy never restarts the row walk
   a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start && row != IW'(STEPS - 1)) |=> (row == $past(row) + IW'(1)));

endmodule

// File: rtl/vmx_mat_regs.sv
module vmx_mat_regs
   import vmx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N      = DIM,
   localparam int IW    = $clog2(N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IW-1:0]             wr_row,
   input  logic [IW-1:0]             wr_col,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      lock,
   input  logic [IW-1:0]             rd_row,
   output logic [N-1:0][DATA_W-1:0]  rd_vec
);

   logic [N-1:0][N-1:0][DATA_W-1:0] mat_q;
   logic                            wr_ok;

   assign wr_ok = wr_en && !lock;

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         logic hit;
         assign hit = wr_ok && (wr_row == IW'(r)) && (wr_col == IW'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mat_q[r][c] <= '0;
            else if (hit) mat_q[r][c] <= wr_data;
         end
      end
   end

   assign rd_vec = mat_q[rd_row];

   // R8: nothing in the matrix moves while a transform runs
   a_r8_locked_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(mat_q));

   // R8: an idle write lands in the addressed element
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lock) |=> (mat_q[$past(wr_row)][$past(wr_col)] == $past(wr_data)));

endmodule

// File: rtl/vmx_cmp_mux.sv
module vmx_cmp_mux #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 16,
   parameter int COMPS  = 3,
   localparam int IW    = $clog2(COMPS + 1)
) (
   input  logic [COMPS-1:0][DATA_W-1:0] vtx,
   input  logic [IW-1:0]                sel,
   output logic [DATA_W-1:0]            comp
);

   localparam logic [DATA_W-1:0] UNIT = DATA_W'(1) << FRAC_W;

   always_comb begin
      comp = UNIT;
      for (int i = 0; i < COMPS; i++) begin
         if (sel == IW'(i)) comp = vtx[i];
      end
   end

endmodule

// File: rtl/vmx_mac.sv
module vmx_mac #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 16,
   localparam int PW    = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              init,
   input  logic [DATA_W-1:0] mul_a,
   input  logic [DATA_W-1:0] mul_b,
   output logic [DATA_W-1:0] acc
);

   logic [PW-1:0]     a_ext, b_ext, prod;
   logic [DATA_W-1:0] scaled, base, acc_q;

   // Sign extension to the full product width keeps the low PW bits exact.
   assign a_ext  = {{DATA_W{mul_a[DATA_W-1]}}, mul_a};
   assign b_ext  = {{DATA_W{mul_b[DATA_W-1]}}, mul_b};
   assign prod   = a_ext * b_ext;
   assign scaled = DATA_W'(prod >> FRAC_W);
   assign base   = init ? '0 : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= base + scaled;
   end

   assign acc = acc_q;

   // R6: an initialising step leaves only the current scaled product
   a_r6_init_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (en && init) |=> (acc == $past(scaled)));

   // R3: later steps wrap-add the scaled product onto the running sum
   a_r3_wrap_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !init) |=> (acc == DATA_W'($past(acc) + $past(scaled))));

endmodule

// File: rtl/vmat4_xform.sv
module vmat4_xform
   import vmx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_row,
   input  logic [IDX_W-1:0]  cfg_col,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              start,
   input  logic [DATA_W-1:0] vtx_x,
   input  logic [DATA_W-1:0] vtx_y,
   input  logic [DATA_W-1:0] vtx_z,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] out_x,
   output logic [DATA_W-1:0] out_y,
   output logic [DATA_W-1:0] out_z,
   output logic [DATA_W-1:0] out_w
);

   if (DATA_W < 8) begin : g_bad_width
      $error("vmat4_xform: DATA_W must be at least 8");
   end
   if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_bad_frac
      $error("vmat4_xform: FRAC_W must lie in 1..DATA_W-1");
   end

   logic                            accept, acc_en, step_init;
   logic [IDX_W-1:0]                step_row;
   logic [COMPS-1:0][DATA_W-1:0]    vtx_q;
   logic [DIM-1:0][DATA_W-1:0]      row_vec;
   logic [DIM-1:0][DATA_W-1:0]      acc;
   logic [DATA_W-1:0]               comp;

   vmx_seq #(.STEPS(DIM)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .done   (done),
      .accept (accept),
      .acc_en (acc_en),
      .init   (step_init),
      .row    (step_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vtx_q <= '0;
      else if (accept) vtx_q <= {vtx_z, vtx_y, vtx_x};
   end

   vmx_mat_regs #(.DATA_W(DATA_W), .N(DIM)) u_mat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_row  (cfg_row),
      .wr_col  (cfg_col),
      .wr_data (cfg_data),
      .lock    (busy),
      .rd_row  (step_row),
      .rd_vec  (row_vec)
   );

   vmx_cmp_mux #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .COMPS(COMPS)) u_mux (
      .vtx  (vtx_q),
      .sel  (step_row),
      .comp (comp)
   );

   for (genvar c = 0; c < DIM; c++) begin : g_col
      vmx_mac #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mac (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (acc_en),
         .init  (step_init),
         .mul_a (comp),
         .mul_b (row_vec[c]),
         .acc   (acc[c])
      );
   end

   assign out_x = acc[0];
   assign out_y = acc[1];
   assign out_z = acc[2];
   assign out_w = acc[3];

   // R7: results are frozen while idle and no start is presented
   a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({out_x, out_y, out_z, out_w}));

   // R10: the captured vertex is frozen for the whole run
   a_r10_vertex_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vtx_q));

   // R4: completion comes exactly five edges after the accepted start
   a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start && !busy, 5));

endmodule

// File: tb/vmat4_xform_tb.sv
module vmat4_xform_tb;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [1:0]    cfg_row, cfg_col;
   logic [DW-1:0] cfg_data;
   logic          start;
   logic [DW-1:0] vtx_x, vtx_y, vtx_z;
   logic          busy, done;
   logic [DW-1:0] out_x, out_y, out_z, out_w;

   logic [DW-1:0] m_sh [4][4];
   logic [DW-1:0] v_sh [3];
   int            n_chk = 0;
   int            n_fail = 0;

   always #5 clk = ~clk;

   vmat4_xform #(.DATA_W(DW), .FRAC_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .cfg_data(cfg_data), .start(start), .vtx_x(vtx_x), .vtx_y(vtx_y), .vtx_z(vtx_z),
      .busy(busy), .done(done), .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_w(out_w)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ref_col(input int c);
      logic [DW-1:0]   acc = '0;
      logic [DW-1:0]   a;
      logic [2*DW-1:0] p;
      for (int r = 0; r < 4; r++) begin
         a = (r < 3) ? v_sh[r] : 32'h0001_0000;
         p = {{DW{a[DW-1]}}, a} * {{DW{m_sh[r][c][DW-1]}}, m_sh[r][c]};
         acc = acc + p[47:16];
      end
      return acc;
   endfunction

   function automatic logic [DW-1:0] rval();
      if ($urandom % 2 == 0) return $urandom;
      return 32'($signed(int'($urandom % 32'h0010_0000)) - 32'sh0008_0000);
   endfunction

   function automatic logic [DW-1:0] out_of(input int c);
      case (c)
         0: return out_x;
         1: return out_y;
         2: return out_z;
         default: return out_w;
      endcase
   endfunction

   // Idle write of one element (R8); called at a falling edge, returns at one.
   task automatic put(input int r, input int c, input logic [DW-1:0] d);
      cfg_we = 1'b1; cfg_row = 2'(r); cfg_col = 2'(c); cfg_data = d;
      m_sh[r][c] = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_all(input int kind);
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            put(r, c, (kind == 0) ? rval() : ((kind == 1 && r == c) ? 32'h0001_0000 : 32'h0));
   endtask

   // mode 0: plain run; 1: start/write/vertex noise while busy; 2: write with start
   task automatic run_once(input int mode, input string tag);
      logic [DW-1:0] e [4];
      int wr, wc;
      vtx_x = v_sh[0]; vtx_y = v_sh[1]; vtx_z = v_sh[2];
      start = 1'b1;
      if (mode == 2) begin
         wr = $urandom % 4; wc = $urandom % 4;
         cfg_we = 1'b1; cfg_row = 2'(wr); cfg_col = 2'(wc); cfg_data = rval();
         m_sh[wr][wc] = cfg_data;
      end
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
      chk(busy === 1'b1, "R5", "busy after accepted start", 32'(busy), 32'd1);
      if (mode == 1) begin
         wr = $urandom % 4; wc = $urandom % 4;
         start = 1'b1;
         vtx_x = $urandom; vtx_y = $urandom; vtx_z = $urandom;
         cfg_we = 1'b1; cfg_row = 2'(wr); cfg_col = 2'(wc); cfg_data = ~m_sh[wr][wc];
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(done === 1'b0, "R4", "done early", 32'(done), 32'd0);
      end
      start = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      chk(done === 1'b1 && busy === 1'b1, "R4", "done at fifth edge", {done, busy}, 2'b11);
      for (int c = 0; c < 4; c++) begin
         e[c] = ref_col(c);
         chk(out_of(c) === e[c], tag, $sformatf("column %0d", c), out_of(c), e[c]);
      end
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R5", "single pulse, back to idle",
          {done, busy}, 2'b00);
      vtx_x = $urandom; vtx_y = $urandom;
      @(negedge clk);
      @(negedge clk);
      for (int c = 0; c < 4; c++)
         chk(out_of(c) === e[c], "R7", $sformatf("hold column %0d", c), out_of(c), e[c]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_row = '0; cfg_col = '0; cfg_data = '0;
      start = 1'b0; vtx_x = '0; vtx_y = '0; vtx_z = '0;
      for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) m_sh[r][c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(busy === 1'b0 && done === 1'b0, "R1", "status after reset", {busy, done}, 2'b00);
      for (int c = 0; c < 4; c++)
         chk(out_of(c) === '0, "R1", $sformatf("column %0d after reset", c), out_of(c), '0);
      v_sh[0] = 32'h0003_0000; v_sh[1] = 32'hFFFE_0000; v_sh[2] = 32'h0001_8000;
      run_once(0, "R1");   // zero matrix from reset gives zero

      // R2: identity passes the vertex with w = 1.0
      load_all(1);
      v_sh[0] = 32'h0001_8800; v_sh[1] = 32'hFFFC_1900; v_sh[2] = 32'hFFF9_1B00;
      run_once(0, "R2");

      // R3: rounding toward minus infinity, and wrap at full range
      load_all(2);
      put(0, 0, 32'h0000_0001);
      put(1, 1, 32'h8000_0000);
      put(2, 2, 32'h7FFF_FFFF);
      put(3, 3, 32'h7FFF_0000);
      v_sh[0] = 32'hFFFF_FFFF; v_sh[1] = 32'h8000_0000; v_sh[2] = 32'h7FFF_FFFF;
      run_once(0, "R3");

      // R6: back-to-back runs with different vertices stay independent
      load_all(0);
      v_sh[0] = $urandom; v_sh[1] = $urandom; v_sh[2] = $urandom;
      run_once(0, "R6");
      v_sh[0] = 32'h0; v_sh[1] = 32'h0; v_sh[2] = 32'h0;
      run_once(0, "R6");

      // Busy noise (R5 R8 R10), then a check that the discarded write stayed out
      v_sh[0] = rval(); v_sh[1] = rval(); v_sh[2] = rval();
      run_once(1, "R10");
      run_once(0, "R8");

      // R9: write and start in the same cycle
      v_sh[0] = rval(); v_sh[1] = rval(); v_sh[2] = rval();
      run_once(2, "R9");

      // Seeded random mix of all modes
      for (int it = 0; it < 30; it++) begin
         if (it % 5 == 0) load_all(0);
         for (int k = 0; k < 3; k++) v_sh[k] = rval();
         run_once(it % 3, (it % 3 == 1) ? "R10" : ((it % 3 == 2) ? "R9" : "R2"));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule